// File: doc/BRIEF.md
# Power-Management Event and Control Register Block

This block is a small register file for system power management. It is reached over a simple single-cycle access port at a relocatable base address. It holds four kinds of state: a 16-bit event status word and its 16-bit enable word, a 16-bit control word, and a 32-bit free-running timer that can only be read. It also has a 32-bit system-management enable word and a byte-addressed bank of general-purpose event status and enable bytes. A level interrupt, `sci`, is raised while any of four event classes is both pending and enabled. These classes are timer overflow, power button, global lock and real-time clock.

Each register answers only to its own access width. A wider access to a register that lacks that width is split into two narrower sub-accesses at consecutive addresses, and the split continues down to bytes if needed. For a split write, the low part of the write data goes to the lower address. For a split read, the result from the lower address lands in the upper part of the returned value. The base address is loaded from outside. While the base is zero, the block decodes nothing.

Hardware events set status bits, and those bits stay set. Software clears a status bit by writing a one to it. The power-button request, the global-lock and real-time-clock event inputs, the timer overflow and the general-purpose event lines all act as hardware events.

Top module: `pm_regblk`

## Requirements
- R1: After reset the base address is zero and every status, enable, control, timer, system-management and general-purpose byte register reads back as zero once a base is loaded. `sci` is low.
- R2: The base register keeps only address bits [15:6]. While the base is zero no access is decoded: reads return 0 and writes have no effect. Once a base is loaded, only addresses inside the 64-byte window at that base are decoded.
- R3: `sci` is high exactly when (status AND enable) is nonzero in at least one of bits 0 (timer), 5 (global lock), 8 (power button) or 10 (real-time clock). A status bit whose enable bit is clear never raises `sci`.
- R4: The event status word at offset 0x00 is write-one-to-clear. If a hardware event arrives in the same cycle as a clearing write to its bit, the event wins and the bit stays set.
- R5: The following accesses go straight to their registers. Halfword (size code 1) at offsets 0x00, 0x02 and 0x04 reaches the status, enable and control words. Word (size code 2) at offset 0x08 reads the timer, and word at offset 0x30 reaches the system-management enable. Byte (size code 0) at offsets 0x20 to 0x27 reaches the general-purpose bank: status bytes at 0x20 to 0x23 and enable bytes at 0x24 to 0x27.
- R6: A word access to a 16-bit register becomes two halfword accesses, at offset +0 with data[15:0] and at offset +2 with data[31:16]. The read returns {half(+0), half(+2)}.
- R7: A halfword access to the byte bank becomes byte accesses at +0 with data[7:0] and at +1 with data[15:8], and the read returns {byte(+0), byte(+1)}. A word access to the bank splits first into halves and then into bytes, so the read returns {b0, b1, b2, b3}.
- R8: A byte sub-access outside 0x20 to 0x27 reads 0 and is ignored on write. This covers byte accesses to the 16-bit words and halfword accesses to the 32-bit registers.
- R9: The timer increases by one on each cycle where `tick` is high and holds otherwise. Writes never change it.
- R10: Timer status (bit 0) is set when timer bit TMR_FLAG_BIT changes value on a tick while enable bit 0 is set. It is not set while enable bit 0 is clear.
- R11: `pwrbtn_req` sets status bit 8, `glk_evt` sets bit 5 and `rtc_evt` sets bit 10. `gpe_evt[i]` sets bit i of the general-purpose status bytes, which are write-one-to-clear. All of these bits remain set until software clears them.
- R12: `sci` reflects a write to the status or enable word from the cycle right after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_wr | input | 1 | Load the base address register |
| base_in | input | 16 | New base address; bits [5:0] are dropped |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 no access |
| req_addr | input | 16 | Access address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for the current access; 0 when nothing is decoded |
| tick | input | 1 | Timer reference enable |
| pwrbtn_req | input | 1 | Power-button request |
| glk_evt | input | 1 | Global-lock event |
| rtc_evt | input | 1 | Real-time-clock event |
| gpe_evt | input | 32 | General-purpose event lines |
| sci | output | 1 | Level interrupt |

## Verification
A hardware event setting a status bit and a software write clearing the same bit can land on the same clock edge. The bench provokes this by holding `pwrbtn_req` high during the very cycle in which a one-to-clear write to bit 8 is presented. It then judges the result by reading bit 8 back as still set and by seeing `sci` remain high. A later clearing write without the event must then drop both.

// File: rtl/pm_pkg.sv
package pm_pkg;

  localparam int unsigned OFF_W = 6;
  typedef logic [OFF_W-1:0] off_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  // register window layout; adjacency of status/enable matters for splitting
  localparam off_t OFF_STS = 6'h00;
  localparam off_t OFF_EN  = 6'h02;
  localparam off_t OFF_CNT = 6'h04;
  localparam off_t OFF_TMR = 6'h08;
  localparam off_t OFF_GPE = 6'h20;
  localparam off_t OFF_SMI = 6'h30;

  localparam int unsigned BIT_TMR = 0;
  localparam int unsigned BIT_GLK = 5;
  localparam int unsigned BIT_PWR = 8;
  localparam int unsigned BIT_RTC = 10;
  localparam logic [15:0] SCI_MASK = (16'd1 << BIT_TMR) | (16'd1 << BIT_GLK) |
                                     (16'd1 << BIT_PWR) | (16'd1 << BIT_RTC);

  typedef struct packed {
    logic      vld;
    acc_size_e size;
    off_t      off;
    logic [31:0] data;
  } leaf_t;

  function automatic logic in_gpe(input off_t off, input int unsigned len);
    return (32'(off) >= 32'(OFF_GPE)) && (32'(off) < 32'(OFF_GPE) + len);
  endfunction

  function automatic logic is_native(input off_t off, input acc_size_e sz,
                                     input int unsigned len);
    case (sz)
      SZ_BYTE: return in_gpe(off, len);
      SZ_HALF: return (off == OFF_STS) || (off == OFF_EN) || (off == OFF_CNT);
      SZ_WORD: return (off == OFF_TMR) || (off == OFF_SMI);
      default: return 1'b0;
    endcase
  endfunction

  function automatic leaf_t mk_leaf(input acc_size_e sz, input off_t off,
                                    input logic [31:0] d);
    leaf_t l;
    l.vld  = 1'b1;
    l.size = sz;
    l.off  = off;
    l.data = d;
    return l;
  endfunction

  // first sub-result goes to the upper part
  function automatic logic [15:0] join_bytes(input logic [7:0] first,
                                             input logic [7:0] second);
    return {first, second};
  endfunction

endpackage

// File: rtl/pm_access_split.sv
module pm_access_split
  import pm_pkg::*;
#(
  parameter int unsigned GPE_LEN = 8
) (
  input  logic              acc_vld_i,
  input  acc_size_e         size_i,
  input  off_t              off_i,
  input  logic [31:0]       wdata_i,
  output leaf_t [3:0]       leaf_o,
  input  logic [3:0][31:0]  leaf_rd_i,
  output logic [31:0]       rdata_o
);

  logic nat;
  logic split_word;
  logic split_half;
  off_t half_off [2];
  logic [15:0] half_val [2];

  assign nat        = is_native(off_i, size_i, GPE_LEN);
  assign split_word = !nat && (size_i == SZ_WORD);
  assign split_half = !nat && (size_i == SZ_HALF);
  assign half_off[0] = off_i;
  assign half_off[1] = off_i + off_t'(2);

  always_comb begin
    leaf_o = '0;
    if (acc_vld_i) begin
      if (split_word) begin
        for (int h = 0; h < 2; h++) begin
          if (is_native(half_off[h], SZ_HALF, GPE_LEN)) begin
            leaf_o[2*h] = mk_leaf(SZ_HALF, half_off[h], {16'h0, wdata_i[16*h +: 16]});
          end else begin
            leaf_o[2*h]   = mk_leaf(SZ_BYTE, half_off[h], {24'h0, wdata_i[16*h +: 8]});
            leaf_o[2*h+1] = mk_leaf(SZ_BYTE, half_off[h] + off_t'(1),
                                    {24'h0, wdata_i[16*h+8 +: 8]});
          end
        end
      end else if (split_half) begin
        leaf_o[0] = mk_leaf(SZ_BYTE, off_i, {24'h0, wdata_i[7:0]});
        leaf_o[1] = mk_leaf(SZ_BYTE, off_i + off_t'(1), {24'h0, wdata_i[15:8]});
      end else if (size_i != SZ_NONE) begin
        leaf_o[0] = mk_leaf(size_i, off_i, wdata_i);
      end
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_val[h] = (leaf_o[2*h].size == SZ_HALF) ? leaf_rd_i[2*h][15:0]
                       : join_bytes(leaf_rd_i[2*h][7:0], leaf_rd_i[2*h+1][7:0]);
  end

  always_comb begin
    if (!acc_vld_i)      rdata_o = '0;
    else if (split_word) rdata_o = {half_val[0], half_val[1]};
    else if (split_half) rdata_o = {16'h0, join_bytes(leaf_rd_i[0][7:0], leaf_rd_i[1][7:0])};
    else                 rdata_o = leaf_rd_i[0];
  end

  logic unused_rd_bits;
  assign unused_rd_bits = ^{leaf_rd_i[1][31:8], leaf_rd_i[2][31:16], leaf_rd_i[3][31:8]};

endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int unsigned TMR_W    = 32,
  parameter int unsigned FLAG_BIT = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             flip_o
);

  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + TMR_W'(1);
  assign flip_o  = tick_i && (cnt_inc[FLAG_BIT] != cnt_q[FLAG_BIT]);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_inc;
  end

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i) |-> $stable(cnt_q)); // R9

endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
#(
  parameter int unsigned GPE_LEN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  leaf_t [3:0]            leaf_i,
  output logic [3:0][31:0]       leaf_rd_o,
  input  logic [31:0]            tmr_val_i,
  input  logic                   tmr_flip_i,
  input  logic                   pwrbtn_i,
  input  logic                   glk_i,
  input  logic                   rtc_i,
  input  logic [GPE_LEN*4-1:0]   gpe_evt_i,
  output logic                   sci_o
);

  localparam int unsigned GPE_HALF = GPE_LEN / 2;
  localparam int unsigned GPE_BITS = GPE_LEN * 4;

  logic [15:0] sts_q, en_q, cnt_q;
  logic [15:0] sts_clr, sts_set, en_d, cnt_d;
  logic [31:0] smi_q, smi_d;
  logic [GPE_BITS-1:0] gsts_q, gen_q, gclr, gen_d;

  always_comb begin
    sts_set          = '0;
    sts_set[BIT_TMR] = tmr_flip_i && en_q[BIT_TMR];
    sts_set[BIT_GLK] = glk_i;
    sts_set[BIT_PWR] = pwrbtn_i;
    sts_set[BIT_RTC] = rtc_i;
  end

  // write side: at most one leaf touches any given register byte
  always_comb begin
    int unsigned gidx;
    gidx    = 0;
    sts_clr = '0;
    en_d    = en_q;
    cnt_d   = cnt_q;
    smi_d   = smi_q;
    gclr    = '0;
    gen_d   = gen_q;
    if (wr_i) begin
      for (int k = 0; k < 4; k++) begin
        if (leaf_i[k].vld) begin
          case (leaf_i[k].size)
            SZ_HALF: begin
              if (leaf_i[k].off == OFF_STS) sts_clr = leaf_i[k].data[15:0];
              if (leaf_i[k].off == OFF_EN)  en_d    = leaf_i[k].data[15:0];
              if (leaf_i[k].off == OFF_CNT) cnt_d   = leaf_i[k].data[15:0];
            end
            SZ_WORD: begin
              if (leaf_i[k].off == OFF_SMI) smi_d = leaf_i[k].data;
            end
            SZ_BYTE: begin
              if (in_gpe(leaf_i[k].off, GPE_LEN)) begin
                gidx = 32'(leaf_i[k].off - OFF_GPE);
                if (gidx < GPE_HALF) gclr[gidx*8 +: 8] = leaf_i[k].data[7:0];
                else                 gen_d[(gidx-GPE_HALF)*8 +: 8] = leaf_i[k].data[7:0];
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // read side: one value per leaf, merged by the splitter
  always_comb begin
    int unsigned ridx;
    ridx      = 0;
    leaf_rd_o = '0;
    for (int k = 0; k < 4; k++) begin
      if (leaf_i[k].vld) begin
        case (leaf_i[k].size)
          SZ_HALF: begin
            if (leaf_i[k].off == OFF_STS) leaf_rd_o[k] = {16'h0, sts_q};
            if (leaf_i[k].off == OFF_EN)  leaf_rd_o[k] = {16'h0, en_q};
            if (leaf_i[k].off == OFF_CNT) leaf_rd_o[k] = {16'h0, cnt_q};
          end
          SZ_WORD: begin
            if (leaf_i[k].off == OFF_TMR) leaf_rd_o[k] = tmr_val_i;
            if (leaf_i[k].off == OFF_SMI) leaf_rd_o[k] = smi_q;
          end
          SZ_BYTE: begin
            if (in_gpe(leaf_i[k].off, GPE_LEN)) begin
              ridx = 32'(leaf_i[k].off - OFF_GPE);
              if (ridx < GPE_HALF) leaf_rd_o[k] = {24'h0, gsts_q[ridx*8 +: 8]};
              else                 leaf_rd_o[k] = {24'h0, gen_q[(ridx-GPE_HALF)*8 +: 8]};
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      en_q   <= '0;
      cnt_q  <= '0;
      smi_q  <= '0;
      gsts_q <= '0;
      gen_q  <= '0;
    end else begin
      sts_q  <= (sts_q & ~sts_clr) | sts_set;   // set wins over clear
      en_q   <= en_d;
      cnt_q  <= cnt_d;
      smi_q  <= smi_d;
      gsts_q <= (gsts_q & ~gclr) | gpe_evt_i;
      gen_q  <= gen_d;
    end
  end

  assign sci_o = |(sts_q & en_q & SCI_MASK);

  AST_PWR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pwrbtn_i |=> sts_q[BIT_PWR]); // R11
  AST_PWR_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[BIT_PWR]) |-> $past(pwrbtn_i)); // R4
  AST_TMR_FLAG_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[BIT_TMR]) |-> $past(tmr_flip_i && en_q[BIT_TMR])); // R10
  AST_SCI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    sci_o |-> ((en_q & SCI_MASK) != 16'h0)); // R3
  AST_GPE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (gpe_evt_i != '0) |=> ((gsts_q & $past(gpe_evt_i)) == $past(gpe_evt_i))); // R11

endmodule

// File: rtl/pm_regblk.sv
module pm_regblk
  import pm_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned GPE_LEN      = 8,
  parameter int unsigned TMR_FLAG_BIT = 23
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  base_wr,
  input  logic [ADDR_W-1:0]     base_in,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [31:0]           req_wdata,
  output logic [31:0]           rsp_rdata,
  input  logic                  tick,
  input  logic                  pwrbtn_req,
  input  logic                  glk_evt,
  input  logic                  rtc_evt,
  input  logic [GPE_LEN*4-1:0]  gpe_evt,
  output logic                  sci
);

  localparam int unsigned TMR_W = 32;

  logic [ADDR_W-1:0] base_q;
  logic              hit;
  logic              acc_vld;
  acc_size_e         req_sz;
  off_t              req_off;
  leaf_t [3:0]       leaves;
  logic [3:0][31:0]  leaf_rd;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_wr) base_q <= {base_in[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  end

  assign hit     = (base_q != '0) && (req_addr[ADDR_W-1:OFF_W] == base_q[ADDR_W-1:OFF_W]);
  assign acc_vld = req_valid && hit;
  assign req_sz  = acc_size_e'(req_size);
  assign req_off = req_addr[OFF_W-1:0];

  pm_access_split #(.GPE_LEN(GPE_LEN)) u_split (
    .acc_vld_i (acc_vld),
    .size_i    (req_sz),
    .off_i     (req_off),
    .wdata_i   (req_wdata),
    .leaf_o    (leaves),
    .leaf_rd_i (leaf_rd),
    .rdata_o   (rsp_rdata)
  );

  pm_timer #(.TMR_W(TMR_W), .FLAG_BIT(TMR_FLAG_BIT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .cnt_o  (tmr_val),
    .flip_o (tmr_flip)
  );

  pm_regs #(.GPE_LEN(GPE_LEN)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (req_write),
    .leaf_i     (leaves),
    .leaf_rd_o  (leaf_rd),
    .tmr_val_i  (tmr_val),
    .tmr_flip_i (tmr_flip),
    .pwrbtn_i   (pwrbtn_req),
    .glk_i      (glk_evt),
    .rtc_i      (rtc_evt),
    .gpe_evt_i  (gpe_evt),
    .sci_o      (sci)
  );

  logic unused_base_bits;
  assign unused_base_bits = ^base_in[OFF_W-1:0];

  AST_BASE0_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (base_q == '0) |-> !hit); // R2
  AST_NO_HIT_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rsp_rdata == 32'h0)); // R2

endmodule

// File: tb/pm_regblk_tb_top.sv
`timescale 1ns/1ps
module pm_regblk_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_wr = 1'b0;
  logic [15:0] base_in = '0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [1:0] req_size = 2'd3;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic tick = 1'b0;
  logic pwrbtn_req = 1'b0;
  logic glk_evt = 1'b0;
  logic rtc_evt = 1'b0;
  logic [31:0] gpe_evt = '0;
  logic sci;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [15:0] BASE = 16'h0400;

  always #10 clk = ~clk;

  pm_regblk #(.TMR_FLAG_BIT(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_in(base_in),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .tick(tick), .pwrbtn_req(pwrbtn_req), .glk_evt(glk_evt), .rtc_evt(rtc_evt),
    .gpe_evt(gpe_evt), .sci(sci)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [7:0]  off;
    logic [31:0] d;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 8'h02, 32'h0000_0521, 32'h0, 4'd5},   // R5 enable write
    '{1'b0, 2'd1, 8'h02, 32'h0, 32'h0000_0521, 4'd5},   // R5
    '{1'b1, 2'd1, 8'h04, 32'h0000_BEEF, 32'h0, 4'd5},   // R5 control
    '{1'b0, 2'd1, 8'h04, 32'h0, 32'h0000_BEEF, 4'd5},   // R5
    '{1'b1, 2'd2, 8'h30, 32'hCAFE_F00D, 32'h0, 4'd5},   // R5 sm enable
    '{1'b0, 2'd2, 8'h30, 32'h0, 32'hCAFE_F00D, 4'd5},   // R5
    '{1'b0, 2'd1, 8'h30, 32'h0, 32'h0, 4'd8},           // R8 half to word reg
    '{1'b1, 2'd0, 8'h02, 32'h0000_00FF, 32'h0, 4'd8},   // R8 byte write ignored
    '{1'b0, 2'd1, 8'h02, 32'h0, 32'h0000_0521, 4'd8},   // R8
    '{1'b1, 2'd2, 8'h00, 32'h1234_0000, 32'h0, 4'd6},   // R6 word split write
    '{1'b0, 2'd1, 8'h02, 32'h0, 32'h0000_1234, 4'd6},   // R6
    '{1'b0, 2'd2, 8'h00, 32'h0, 32'h0000_1234, 4'd6},   // R6 word split read
    '{1'b1, 2'd2, 8'h00, 32'h0521_0000, 32'h0, 4'd6},   // R6
    '{1'b0, 2'd2, 8'h00, 32'h0, 32'h0000_0521, 4'd6},   // R6
    '{1'b1, 2'd0, 8'h24, 32'h0000_005A, 32'h0, 4'd5},   // R5 bank byte
    '{1'b0, 2'd0, 8'h24, 32'h0, 32'h0000_005A, 4'd5},   // R5
    '{1'b1, 2'd1, 8'h26, 32'h0000_3C99, 32'h0, 4'd7},   // R7 half to bytes
    '{1'b0, 2'd1, 8'h26, 32'h0, 32'h0000_993C, 4'd7},   // R7
    '{1'b0, 2'd2, 8'h24, 32'h0, 32'h5A00_993C, 4'd7},   // R7
    '{1'b1, 2'd2, 8'h24, 32'h1122_3344, 32'h0, 4'd7},   // R7 word to bytes
    '{1'b0, 2'd2, 8'h24, 32'h0, 32'h4433_2211, 4'd7},   // R7
    '{1'b0, 2'd1, 8'h24, 32'h0, 32'h0000_4433, 4'd7},   // R7
    '{1'b1, 2'd2, 8'h08, 32'hFFFF_FFFF, 32'h0, 4'd9},   // R9 timer read-only
    '{1'b0, 2'd2, 8'h08, 32'h0, 32'h0, 4'd9},           // R9
    '{1'b0, 2'd0, 8'h00, 32'h0, 32'h0, 4'd8},           // R8 byte outside bank
    '{1'b0, 2'd2, 8'h10, 32'h0, 32'h0, 4'd8},           // R8 unused offset
    '{1'b1, 2'd1, 8'h30, 32'h0000_FFFF, 32'h0, 4'd8},   // R8 ignored
    '{1'b0, 2'd2, 8'h30, 32'h0, 32'hCAFE_F00D, 4'd8}    // R8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [1:0] sz, input logic [15:0] addr,
                     input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = d;
    #2 rd = rsp_rdata;
    @(posedge clk);
    #1 req_valid = 1'b0; req_write = 1'b0; req_size = 2'd3;
  endtask

  task automatic wr_acc(input logic [1:0] sz, input logic [7:0] off, input logic [31:0] d);
    logic [31:0] rd;
    bus(1'b1, sz, BASE | 16'(off), d, rd);
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] sz, input logic [7:0] off,
                        input logic [31:0] exp);
    logic [31:0] rd;
    bus(1'b0, sz, BASE | 16'(off), 32'h0, rd);
    chk(tag, rd, exp);
  endtask

  task automatic load_base(input logic [15:0] b);
    @(negedge clk); base_wr = 1'b1; base_in = b;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sci after reset", 32'(sci), 32'h0);
    // base is zero: nothing decoded
    bus(1'b1, 2'd1, 16'h0002, 32'h0000_FFFF, rd);
    bus(1'b0, 2'd1, 16'h0002, 32'h0, rd);
    chk("R2 read with zero base", rd, 32'h0);
    load_base(BASE | 16'h0013);                   // low bits dropped
    rd_chk("R2 write under zero base ignored", 2'd1, 8'h02, 32'h0);
    rd_chk("R1 reset status", 2'd1, 8'h00, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr_acc(VEC[i].sz, VEC[i].off, VEC[i].d);
      else rd_chk($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].sz, VEC[i].off, VEC[i].exp);
    end

    bus(1'b0, 2'd1, 16'h0802, 32'h0, rd);
    chk("R2 other window", rd, 32'h0);

    // R11 / R3: power button with enable bit 8 set
    @(negedge clk); pwrbtn_req = 1'b1;
    @(negedge clk); pwrbtn_req = 1'b0;
    chk("R11 pwrbtn raises sci", 32'(sci), 32'h1);
    rd_chk("R11 pwrbtn status sticky", 2'd1, 8'h00, 32'h0000_0100);
    // R4: event and clearing write in the same cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd1;
    req_addr = BASE; req_wdata = 32'h0000_0100; pwrbtn_req = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0; req_write = 1'b0; req_size = 2'd3; pwrbtn_req = 1'b0;
    @(negedge clk);
    chk("R4 event wins over clear sci", 32'(sci), 32'h1);
    rd_chk("R4 event wins over clear", 2'd1, 8'h00, 32'h0000_0100);
    wr_acc(2'd1, 8'h00, 32'h0000_0100);
    chk("R12 sci drops after clear", 32'(sci), 32'h0);
    rd_chk("R4 clear", 2'd1, 8'h00, 32'h0);

    // R3: masked by enable
    wr_acc(2'd1, 8'h02, 32'h0000_0421);
    @(negedge clk); pwrbtn_req = 1'b1;
    @(negedge clk); pwrbtn_req = 1'b0;
    chk("R3 disabled class keeps sci low", 32'(sci), 32'h0);
    wr_acc(2'd1, 8'h02, 32'h0000_0521);
    chk("R12 sci rises after enable write", 32'(sci), 32'h1);
    wr_acc(2'd1, 8'h00, 32'h0000_0100);

    // R11 / R3: global lock and real-time clock
    @(negedge clk); glk_evt = 1'b1;
    @(negedge clk); glk_evt = 1'b0; rtc_evt = 1'b1;
    @(negedge clk); rtc_evt = 1'b0;
    chk("R3 glk/rtc sci", 32'(sci), 32'h1);
    rd_chk("R11 glk and rtc status", 2'd1, 8'h00, 32'h0000_0420);
    wr_acc(2'd1, 8'h00, 32'h0000_0420);
    chk("R3 sci low after clear", 32'(sci), 32'h0);

    // R10 / R9: timer flag (bench uses flag bit 4)
    wr_acc(2'd1, 8'h02, 32'h0000_0520);
    ticks(16);
    rd_chk("R9 timer count", 2'd2, 8'h08, 32'd16);
    rd_chk("R10 no flag while disabled", 2'd1, 8'h00, 32'h0);
    wr_acc(2'd1, 8'h02, 32'h0000_0521);
    ticks(16);
    rd_chk("R9 timer count 2", 2'd2, 8'h08, 32'd32);
    rd_chk("R10 flag set when enabled", 2'd1, 8'h00, 32'h0000_0001);
    chk("R10 timer sci", 32'(sci), 32'h1);
    wr_acc(2'd1, 8'h00, 32'h0000_0001);

    // R11: bank status events and one-to-clear
    @(negedge clk); gpe_evt = 32'h0000_0008;
    @(negedge clk); gpe_evt = '0;
    rd_chk("R11 bank event", 2'd0, 8'h20, 32'h0000_0008);
    wr_acc(2'd0, 8'h20, 32'h0000_0008);
    rd_chk("R11 bank clear", 2'd0, 8'h20, 32'h0);

    // R1: second reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 sci after reset 2", 32'(sci), 32'h0);
    bus(1'b0, 2'd1, BASE | 16'h0002, 32'h0, rd);
    chk("R1 base cleared", rd, 32'h0);
    load_base(BASE);
    rd_chk("R1 enable cleared", 2'd1, 8'h02, 32'h0);
    rd_chk("R1 control cleared", 2'd1, 8'h04, 32'h0);
    rd_chk("R1 sm enable cleared", 2'd2, 8'h30, 32'h0);
    rd_chk("R1 bank cleared", 2'd2, 8'h24, 32'h0);
    rd_chk("R1 timer cleared", 2'd2, 8'h08, 32'h0);
    summary();
  end

endmodule